// File: doc/BRIEF.md
# Two-Tier Packet Round-Robin DMA Arbiter

This block decides which of N FIFOs gets DMA service next. Each FIFO has a priority bit that places it in either the high group or the low group. A FIFO takes part in arbitration only when two things are both true: its request queue holds work, and its data side is ready. For transmit, ready means the FIFO has room. For receive, ready means the FIFO holds the data needed. The high group always wins over the low group. Inside each group, grants rotate round-robin.

Grants cover a whole packet. Once a FIFO holds the grant, it keeps it until the DMA engine raises the packet-done strobe. This means a scatter-gather packet made of several requests is never split across FIFOs. An optional debug channel occupies index N. A 2-bit level code places it in one of three positions:
- normal: it joins the low round-robin group;
- high: it sits between the two groups;
- low: it sits below everything else.

The grant is a registered one-hot vector. The DMA engine itself is outside this block.

Top module: `dma_prio_arb`

## Requirements
- R1: FIFO n is eligible only when `req_pend[n]` and `data_ok[n]` are both 1. The same holds for the debug channel with `dbg_pend` and `dbg_ok`. When nothing is eligible, the grant stays all-zero.
- R2: After reset, the grant is all-zero and both round-robin pointers start before index 0. The first search in either group therefore begins at index 0.
- R3: When no grant is held and at least one eligible FIFO has `prio_hi[n]=1`, the grant goes to one of them. The choice is the first such index after the last high-group FIFO to complete a packet, searching upward and wrapping.
- R4: Low-group FIFOs (`prio_hi[n]=0`) are granted only when no high-group FIFO is eligible. They are chosen round-robin with their own pointer, which moves only on low-group completions.
- R5: A held grant does not change, whatever the eligibility and priority inputs do, until `pkt_done` is 1.
- R6: `pkt_done=1` while a grant is held clears the grant at that clock edge. That cycle also moves the owning group's pointer to the granted index. A new grant can appear no earlier than the following edge.
- R7: Debug level code 2'b10 (high) grants the debug channel (grant bit N) ahead of every low-group FIFO and behind every high-group FIFO.
- R8: Debug level code 2'b01 (low) grants the debug channel only when no other FIFO is eligible.
- R9: Debug level code 2'b00, and the unused code 2'b11, make the debug channel index N of the low round-robin group.
- R10: The grant is one-hot or all-zero. It is registered: inputs seen in an idle cycle set the grant at the next clock edge.
- R11: `pkt_done` while no grant is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pend | input | N | Request queue of FIFO n is non-empty |
| data_ok | input | N | FIFO n has room (TX) or data (RX) |
| prio_hi | input | N | 1 puts FIFO n in the high group |
| dbg_pend | input | 1 | Debug channel queue non-empty |
| dbg_ok | input | 1 | Debug channel FIFO ready |
| dbg_level | input | 2 | Debug level: 00 normal, 01 low, 10 high, 11 as normal |
| pkt_done | input | 1 | Last transfer of the granted packet is acknowledged |
| grant | output | N+DBG_EN | One-hot grant; bit N is the debug channel |

## Verification
The bench drives every input at a falling edge. A grant decided from idle-cycle inputs is due at the next rising edge. A release caused by `pkt_done` is also due at that same edge, and the grant then stays zero for at least one full cycle. The behavioural model applies each transition at the moment it drives the inputs. The model's expected grant is then compared with the output at the following falling edge, so every result is sampled exactly one register stage after its cause. Both directed phases and random phases run through this same compare.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_HI   = 2'd1,
        GRP_LO   = 2'd2,
        GRP_SOLO = 2'd3
    } grp_e;

    localparam logic [1:0] DLVL_NORMAL = 2'b00;
    localparam logic [1:0] DLVL_LOW    = 2'b01;
    localparam logic [1:0] DLVL_HIGH   = 2'b10;

    typedef struct packed {
        logic valid;
        grp_e grp;
    } pick_t;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic lvl_is_normal(input logic [1:0] lvl);
        return !(lvl == DLVL_LOW || lvl == DLVL_HIGH);
    endfunction

endpackage

// File: rtl/arb_tier_map.sv
module arb_tier_map
    import arb_pkg::*;
#(
    parameter int N      = 8,
    parameter int DBG_EN = 1,
    parameter int NT     = N + DBG_EN
) (
    input  logic [N-1:0]  req_pend,
    input  logic [N-1:0]  data_ok,
    input  logic [N-1:0]  prio_hi,
    input  logic          dbg_pend,
    input  logic          dbg_ok,
    input  logic [1:0]    dbg_level,
    output logic [NT-1:0] req_hi,
    output logic [NT-1:0] req_lo,
    output logic          dbg_up,
    output logic          dbg_dn
);
    logic [N-1:0] elig;
    assign elig = req_pend & data_ok;

    generate
        if (DBG_EN != 0) begin : g_dbg
            logic dbg_e;
            assign dbg_e  = dbg_pend & dbg_ok;
            assign req_hi = {1'b0, elig & prio_hi};
            assign req_lo = {dbg_e & lvl_is_normal(dbg_level), elig & ~prio_hi};
            assign dbg_up = dbg_e & (dbg_level == DLVL_HIGH);
            assign dbg_dn = dbg_e & (dbg_level == DLVL_LOW);
        end else begin : g_nodbg
            logic unused_dbg;
            assign unused_dbg = ^{dbg_pend, dbg_ok, dbg_level};
            assign req_hi = elig & prio_hi;
            assign req_lo = elig & ~prio_hi;
            assign dbg_up = 1'b0;
            assign dbg_dn = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
    import arb_pkg::*;
#(
    parameter int NT = 9,
    parameter int IW = idx_bits(NT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] req,
    input  logic [IW-1:0] ptr,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 1; k <= NT; k++) begin
            logic [IW:0] c;
            c = {1'b0, ptr} + (IW+1)'(k);
            if (c >= (IW+1)'(NT)) c = c - (IW+1)'(NT);
            if (!valid && req[c[IW-1:0]]) begin
                valid = 1'b1;
                idx   = c[IW-1:0];
            end
        end
    end

    AST_PICK_IS_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        valid |-> req[idx]) else $error("pick outside request set"); // R3

    AST_PICK_WHEN_ANY: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> valid) else $error("request set ignored"); // R4

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import arb_pkg::*;
#(
    parameter int N      = 8,
    parameter int DBG_EN = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        req_pend,
    input  logic [N-1:0]        data_ok,
    input  logic [N-1:0]        prio_hi,
    input  logic                dbg_pend,
    input  logic                dbg_ok,
    input  logic [1:0]          dbg_level,
    input  logic                pkt_done,
    output logic [N+DBG_EN-1:0] grant
);
    localparam int NT = N + DBG_EN;
    localparam int IW = idx_bits(NT);
    localparam logic [IW-1:0] LAST_IDX = IW'(NT - 1);

    logic [NT-1:0] req_hi, req_lo;
    logic          dbg_up, dbg_dn;
    logic          hv, lv;
    logic [IW-1:0] hidx, lidx;
    logic [IW-1:0] ptr_hi, ptr_lo;

    logic [NT-1:0] grant_q;
    logic [IW-1:0] gidx_q;
    grp_e          grp_q;
    logic          busy;

    pick_t         sel;
    logic [IW-1:0] sel_idx;

    arb_tier_map #(.N(N), .DBG_EN(DBG_EN), .NT(NT)) u_map (
        .req_pend (req_pend),
        .data_ok  (data_ok),
        .prio_hi  (prio_hi),
        .dbg_pend (dbg_pend),
        .dbg_ok   (dbg_ok),
        .dbg_level(dbg_level),
        .req_hi   (req_hi),
        .req_lo   (req_lo),
        .dbg_up   (dbg_up),
        .dbg_dn   (dbg_dn)
    );

    arb_rr_pick #(.NT(NT), .IW(IW)) u_pick_hi (
        .clk(clk), .rst(rst), .req(req_hi), .ptr(ptr_hi), .valid(hv), .idx(hidx)
    );

    arb_rr_pick #(.NT(NT), .IW(IW)) u_pick_lo (
        .clk(clk), .rst(rst), .req(req_lo), .ptr(ptr_lo), .valid(lv), .idx(lidx)
    );

    assign busy = |grant_q;

    always_comb begin
        sel     = '{valid: 1'b0, grp: GRP_NONE};
        sel_idx = '0;
        if (hv) begin
            sel     = '{valid: 1'b1, grp: GRP_HI};
            sel_idx = hidx;
        end else if (dbg_up) begin
            sel     = '{valid: 1'b1, grp: GRP_SOLO};
            sel_idx = LAST_IDX;
        end else if (lv) begin
            sel     = '{valid: 1'b1, grp: GRP_LO};
            sel_idx = lidx;
        end else if (dbg_dn) begin
            sel     = '{valid: 1'b1, grp: GRP_SOLO};
            sel_idx = LAST_IDX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            gidx_q  <= '0;
            grp_q   <= GRP_NONE;
            ptr_hi  <= LAST_IDX;
            ptr_lo  <= LAST_IDX;
        end else if (busy) begin
            if (pkt_done) begin
                grant_q <= '0;
                grp_q   <= GRP_NONE;
                if (grp_q == GRP_HI) ptr_hi <= gidx_q;
                if (grp_q == GRP_LO) ptr_lo <= gidx_q;
            end
        end else if (sel.valid) begin
            grant_q <= NT'(1) << sel_idx;
            gidx_q  <= sel_idx;
            grp_q   <= sel.grp;
        end
    end

    assign grant = grant_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q)) else $error("grant not one-hot"); // R10

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !pkt_done) |=> $stable(grant_q)) else $error("grant moved mid-packet"); // R5

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
        (busy && pkt_done) |=> (grant_q == '0)) else $error("no idle after packet"); // R6

    AST_HI_WINS: assert property (@(posedge clk) disable iff (rst)
        (!busy && (|req_hi)) |=> (|(grant_q & $past(req_hi)))) else $error("high group skipped"); // R3

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(|{req_hi, req_lo, dbg_up, dbg_dn})) |=> (grant_q == '0))
        else $error("grant without eligible FIFO"); // R1

endmodule

// File: tb/tb_dma_prio_arb.sv
module tb_dma_prio_arb;
    localparam int N  = 4;
    localparam int NT = N + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req_pend, data_ok, prio_hi;
    logic          dbg_pend, dbg_ok, pkt_done;
    logic [1:0]    dbg_level;
    logic [NT-1:0] grant;

    int total = 0;
    int bad   = 0;

    int    cur = -1;
    int    grp = 0;
    int    hp  = NT - 1;
    int    lp  = NT - 1;
    string tag = "R2";

    always #5 clk = ~clk;

    dma_prio_arb #(.N(N), .DBG_EN(1)) dut (
        .clk(clk), .rst(rst), .req_pend(req_pend), .data_ok(data_ok),
        .prio_hi(prio_hi), .dbg_pend(dbg_pend), .dbg_ok(dbg_ok),
        .dbg_level(dbg_level), .pkt_done(pkt_done), .grant(grant)
    );

    function automatic logic [NT-1:0] model_grant();
        return (cur >= 0) ? (NT'(1) << cur) : '0;
    endfunction

    task automatic compare();
        logic [NT-1:0] exp_g;
        exp_g = model_grant();
        total++;
        if (grant !== exp_g) begin
            bad++;
            $display("FAIL %s grant act=%b exp=%b", tag, grant, exp_g);
        end
        total++;
        if ($countones(grant) > 1) begin
            bad++;
            $display("FAIL R10 one-hot act=%b exp=at most one bit", grant);
        end
    endtask

    task automatic advance_model();
        int  found;
        int  g;
        bit  de;
        found = -1;
        g     = 0;
        de    = dbg_pend && dbg_ok;
        if (cur >= 0) begin
            if (pkt_done) begin
                if (grp == 1) hp = cur;
                if (grp == 2) lp = cur;
                cur = -1;
                tag = "R6";
            end else begin
                tag = "R5";
            end
        end else begin
            for (int k = 1; k <= NT; k++) begin
                int c;
                c = (hp + k) % NT;
                if (found < 0 && c < N && req_pend[c] && data_ok[c] && prio_hi[c]) begin
                    found = c; g = 1; tag = "R3";
                end
            end
            if (found < 0 && de && dbg_level == 2'b10) begin
                found = N; g = 3; tag = "R7";
            end
            for (int k = 1; k <= NT; k++) begin
                int c;
                bit mem;
                c   = (lp + k) % NT;
                mem = (c < N) ? (req_pend[c] && data_ok[c] && !prio_hi[c])
                              : (de && (dbg_level == 2'b00 || dbg_level == 2'b11));
                if (found < 0 && mem) begin
                    found = c; g = 2;
                    tag = (c == N) ? "R9" : "R4";
                end
            end
            if (found < 0 && de && dbg_level == 2'b01) begin
                found = N; g = 3; tag = "R8";
            end
            if (found < 0) tag = pkt_done ? "R11" : "R1";
            cur = found;
            grp = g;
        end
    endtask

    task automatic step(input logic [N-1:0] p, input logic [N-1:0] o,
                        input logic [N-1:0] h, input logic dp, input logic dk,
                        input logic [1:0] lv, input logic dn);
        @(negedge clk);
        compare();
        req_pend = p; data_ok = o; prio_hi = h;
        dbg_pend = dp; dbg_ok = dk; dbg_level = lv; pkt_done = dn;
        advance_model();
    endtask

    task automatic rand_phase(input int cycles, input logic [N-1:0] hmask,
                              input int dbg_sel, input int done_pct);
        for (int i = 0; i < cycles; i++) begin
            logic [1:0] lv;
            lv = (dbg_sel < 0) ? 2'($urandom) : 2'(dbg_sel);
            step(N'($urandom), N'($urandom | $urandom), N'($urandom) & hmask,
                 1'($urandom), 1'($urandom | $urandom), lv,
                 ($urandom % 100) < done_pct);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_pend = '0; data_ok = '0; prio_hi = '0;
        dbg_pend = 1'b0; dbg_ok = 1'b0; dbg_level = 2'b00; pkt_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tag = "R2";
        // R2: first low grant lands on index 0
        step('1, '1, '0, 1'b0, 1'b0, 2'b00, 1'b0);
        step('1, '1, '0, 1'b0, 1'b0, 2'b00, 1'b0);
        step('1, '1, '0, 1'b0, 1'b0, 2'b00, 1'b1);
        // R1: pending without readiness, and readiness without pending
        step(4'b1010, 4'b0101, '0, 1'b1, 1'b0, 2'b00, 1'b0);
        step(4'b0000, 4'b1111, '0, 1'b0, 1'b1, 2'b00, 1'b0);
        // R11: done while idle
        step('0, '0, '0, 1'b0, 1'b0, 2'b00, 1'b1);
        // R3: high group rotation, R5 lock while requests change
        for (int i = 0; i < 8; i++) begin
            step('1, '1, 4'b0110, 1'b1, 1'b1, 2'b10, 1'b0);
            step('0, '0, 4'b0000, 1'b0, 1'b0, 2'b00, 1'b0);
            step('1, '1, 4'b1001, 1'b0, 1'b0, 2'b00, 1'b1);
        end
        // R7, R8, R9: debug channel levels against low FIFOs
        for (int lv = 0; lv < 4; lv++) begin
            for (int i = 0; i < 6; i++) begin
                step(4'b0011, '1, '0, 1'b1, 1'b1, 2'(lv), 1'b0);
                step(4'b0011, '1, '0, 1'b1, 1'b1, 2'(lv), 1'b1);
            end
            step('0, '0, '0, 1'b1, 1'b1, 2'(lv), 1'b0);
            step('0, '0, '0, 1'b1, 1'b1, 2'(lv), 1'b1);
        end
        // R4: low group only when high group empty
        rand_phase(300, 4'b0000, 0, 40);
        rand_phase(600, 4'b1111, -1, 35);
        rand_phase(600, 4'b0101, 2, 50);
        rand_phase(600, 4'b1111, 1, 30);
        step('0, '0, '0, 1'b0, 1'b0, 2'b00, 1'b1);
        step('0, '0, '0, 1'b0, 1'b0, 2'b00, 1'b0);
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule